// File: doc/BRIEF.md
# Color-Expansion Write Engine

This block turns a single CPU byte write into a run of eight pixel writes on a video memory that stores one byte per pixel. Each bit of the CPU byte picks the color of one pixel. A set bit paints the pixel with the foreground color. A clear bit either leaves the pixel alone (transparent expansion) or paints it with the background color (opaque expansion). Both colors come from two small color registers. A mode-extension flag controls how wide those registers are and which write modes can be reached.

The CPU side presents a bank base and a byte offset; their sum `A` is the byte address. An expansion writes pixels `A*8` to `A*8+7`, one per cycle, on eight back-to-back cycles. While it runs, `busy` is high and further CPU writes are dropped, so the CPU port must stall. The colors are frozen at the start of each expansion. A write in any other write mode goes straight to one memory byte at address `A`.

Top module: `cexp_write_engine`

## Requirements
- R1: A register write with `reg_sel` 0 loads the background color and `reg_sel` 1 loads the foreground color. `reg_sel` 2 loads the wide flag from bit 2 of `reg_wdata`. While the wide flag is set, a color write stores all 8 bits.
- R2: While the wide flag is clear, a color write stores only bits 3:0 of `reg_wdata` and clears bits 7:4 of the color.
- R3: The write mode is masked to its low 3 bits when the wide flag is set and to its low 2 bits when it is clear. Effective mode 4 selects transparent expansion, mode 5 selects opaque expansion, and every other value selects pass-through. Modes 4 and 5 can therefore be reached only with the wide flag set.
- R4: An expansion accepted at a clock edge presents pixel `i` (i = 0..7) in the i-th cycle after that edge, at address `(cpu_base + cpu_off) * 8 + i`.
- R5: Pixel 0 is controlled by data bit 7 and pixel 7 by data bit 0.
- R6: In transparent expansion a pixel whose bit is 1 is written with the foreground color. A pixel whose bit is 0 keeps `mem_we` low in its cycle, and the address still advances.
- R7: In opaque expansion every pixel is written: with the foreground color for a 1 bit, with the background color for a 0 bit.
- R8: `busy` is high for exactly the eight pixel cycles of an expansion. A CPU write presented while `busy` is high is ignored and produces no memory write.
- R9: The colors used by an expansion are those held at its start; register writes made during it apply from the next CPU write.
- R10: Pixel and pass-through addresses wrap modulo 2^MEM_AW.
- R11: A pass-through write drives one memory write in the next cycle, with address `cpu_base + cpu_off` and the CPU byte unchanged, and does not raise `busy`.
- R12: After reset, `busy` and `mem_we` are low, both colors are zero and the wide flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 background, 1 foreground, 2 mode extension |
| reg_wdata | input | 8 | Register write data |
| wmode | input | MODE_W | Write-mode field |
| cpu_we | input | 1 | CPU byte write request |
| cpu_base | input | BASE_W | Bank base address |
| cpu_off | input | BASE_W | Byte offset within the bank |
| cpu_data | input | 8 | CPU write byte |
| busy | output | 1 | Expansion in progress; CPU must stall |
| mem_we | output | 1 | Video memory write enable |
| mem_addr | output | MEM_AW | Video memory pixel address |
| mem_wdata | output | 8 | Video memory pixel data |

## Verification
The bench attacks the bit order, since a design that walked the byte from bit 0 would paint an asymmetric pattern such as 0x96 mirrored. It loads colors with the wide flag clear and then sets the flag, so a design that latched full bytes would show high nibbles that should be zero. It also leaves the flag clear with mode 5, which a design with a 3-bit mask would wrongly expand. It rewrites the foreground in the middle of an expansion and sends a CPU write while `busy` is high. A design that read the live color would change color partway through the run, and one that accepted the stalled write would issue a ninth write. Byte addresses whose `A*8` or `A` overflow the memory check the wrap, which a design with a too-wide address path would miss.

// File: rtl/cexp_pkg.sv
package cexp_pkg;

   // Pixels produced per CPU byte and bits per pixel
   localparam int PIX_PER_BYTE = 8;
   localparam int PIX_W        = 8;
   localparam int PIX_SHIFT    = $clog2(PIX_PER_BYTE);

   // Register select encoding
   typedef enum logic [1:0] {
      SEL_BG   = 2'd0,
      SEL_FG   = 2'd1,
      SEL_EXT  = 2'd2,
      SEL_RSVD = 2'd3
   } reg_sel_e;

   // Kind of transfer a CPU write turns into
   typedef enum logic [1:0] {
      XK_PASS   = 2'd0,
      XK_TRANSP = 2'd1,
      XK_OPAQUE = 2'd2
   } xfer_kind_e;

   // Effective mode codes that expand
   localparam int MODE_TRANSP = 4;
   localparam int MODE_OPAQUE = 5;

endpackage

// File: rtl/cexp_regs.sv
module cexp_regs
   import cexp_pkg::*;
#(
   parameter int EXT_BIT  = 2,
   parameter int NARROW_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_we,
   input  logic [1:0]       reg_sel,
   input  logic [PIX_W-1:0] reg_wdata,
   output logic             wide_q,
   output logic [PIX_W-1:0] bg_q,
   output logic [PIX_W-1:0] fg_q
);

   localparam logic [PIX_W-1:0] NARROW_MASK = PIX_W'((1 << NARROW_W) - 1);

   logic [PIX_W-1:0] color_in;

   // Width gating depends on the flag value before this write
   generate
      if (NARROW_W >= PIX_W) begin : g_full_only
         assign color_in = reg_wdata;
      end else begin : g_gated
         assign color_in = wide_q ? reg_wdata : (reg_wdata & NARROW_MASK);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wide_q <= 1'b0;
         bg_q   <= '0;
         fg_q   <= '0;
      end else if (reg_we) begin
         case (reg_sel_e'(reg_sel))
            SEL_BG:  bg_q   <= color_in;
            SEL_FG:  fg_q   <= color_in;
            SEL_EXT: wide_q <= reg_wdata[EXT_BIT];
            default: ;
         endcase
      end
   end

endmodule

// File: rtl/cexp_mode_decode.sv
module cexp_mode_decode
   import cexp_pkg::*;
#(
   parameter int MODE_W        = 3,
   parameter int NARROW_MODE_W = 2
) (
   input  logic [MODE_W-1:0] wmode,
   input  logic              wide,
   output xfer_kind_e        kind
);

   localparam logic [MODE_W-1:0] NARROW_MASK = MODE_W'((1 << NARROW_MODE_W) - 1);
   localparam logic [MODE_W-1:0] CODE_T      = MODE_W'(MODE_TRANSP);
   localparam logic [MODE_W-1:0] CODE_O      = MODE_W'(MODE_OPAQUE);

   logic [MODE_W-1:0] eff;

   generate
      if (NARROW_MODE_W >= MODE_W) begin : g_no_mask
         assign eff = wmode;
      end else begin : g_masked
         assign eff = wide ? wmode : (wmode & NARROW_MASK);
      end
   endgenerate

   always_comb begin
      if (eff == CODE_T)      kind = XK_TRANSP;
      else if (eff == CODE_O) kind = XK_OPAQUE;
      else                    kind = XK_PASS;
   end

endmodule

// File: rtl/cexp_expander.sv
module cexp_expander
   import cexp_pkg::*;
#(
   parameter int MEM_AW = 16,
   parameter int BASE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  xfer_kind_e        kind,
   input  logic [BASE_W-1:0] base,
   input  logic [BASE_W-1:0] off,
   input  logic [PIX_W-1:0]  data,
   input  logic [PIX_W-1:0]  fg,
   input  logic [PIX_W-1:0]  bg,
   output logic              busy,
   output logic              mem_we,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [PIX_W-1:0]  mem_wdata,
   output logic [PIX_W-1:0]  fg_cap,
   output logic [PIX_W-1:0]  bg_cap
);

   localparam int                CNT_W    = PIX_SHIFT;
   localparam logic [CNT_W-1:0]  LAST_PIX = CNT_W'(PIX_PER_BYTE - 1);
   localparam int                WIDE_W   = BASE_W + PIX_SHIFT;

   logic [BASE_W-1:0]       byte_addr;
   logic [WIDE_W-1:0]       pix_wide;
   logic [MEM_AW-1:0]       pix0;
   logic [MEM_AW-1:0]       pass_addr_n;

   logic                    act_q;
   logic [CNT_W-1:0]        cnt_q;
   logic [PIX_PER_BYTE-1:0] bits_q;
   logic                    opaque_q;
   logic [MEM_AW-1:0]       base_pix_q;
   logic                    pass_v_q;
   logic [MEM_AW-1:0]       pass_addr_q;
   logic [PIX_W-1:0]        pass_data_q;

   // Byte address and its first pixel, both reduced modulo the memory size
   always_comb begin
      byte_addr   = base + off;
      pix_wide    = {byte_addr, {PIX_SHIFT{1'b0}}};
      pix0        = pix_wide[MEM_AW-1:0];
      pass_addr_n = byte_addr[MEM_AW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q       <= 1'b0;
         cnt_q       <= '0;
         bits_q      <= '0;
         opaque_q    <= 1'b0;
         base_pix_q  <= '0;
         fg_cap      <= '0;
         bg_cap      <= '0;
         pass_v_q    <= 1'b0;
         pass_addr_q <= '0;
         pass_data_q <= '0;
      end else begin
         pass_v_q <= 1'b0;
         if (act_q) begin
            // Most significant bit drives the current pixel
            bits_q <= {bits_q[PIX_PER_BYTE-2:0], 1'b0};
            cnt_q  <= cnt_q + 1'b1;
            if (cnt_q == LAST_PIX) act_q <= 1'b0;
         end else if (start) begin
            if (kind == XK_PASS) begin
               pass_v_q    <= 1'b1;
               pass_addr_q <= pass_addr_n;
               pass_data_q <= data;
            end else begin
               act_q      <= 1'b1;
               cnt_q      <= '0;
               bits_q     <= data;
               opaque_q   <= (kind == XK_OPAQUE);
               base_pix_q <= pix0;
               fg_cap     <= fg;
               bg_cap     <= bg;
            end
         end
      end
   end

   always_comb begin
      busy = act_q;
      if (act_q) begin
         mem_we    = opaque_q | bits_q[PIX_PER_BYTE-1];
         mem_addr  = base_pix_q + MEM_AW'(cnt_q);
         mem_wdata = bits_q[PIX_PER_BYTE-1] ? fg_cap : bg_cap;
      end else if (pass_v_q) begin
         mem_we    = 1'b1;
         mem_addr  = pass_addr_q;
         mem_wdata = pass_data_q;
      end else begin
         mem_we    = 1'b0;
         mem_addr  = '0;
         mem_wdata = '0;
      end
   end

endmodule

// File: rtl/cexp_write_engine.sv
module cexp_write_engine
   import cexp_pkg::*;
#(
   parameter int MEM_AW        = 16,
   parameter int BASE_W        = 16,
   parameter int MODE_W        = 3,
   parameter int NARROW_MODE_W = 2,
   parameter int NARROW_W      = 4,
   parameter int EXT_BIT       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [1:0]        reg_sel,
   input  logic [7:0]        reg_wdata,
   input  logic [MODE_W-1:0] wmode,
   input  logic              cpu_we,
   input  logic [BASE_W-1:0] cpu_base,
   input  logic [BASE_W-1:0] cpu_off,
   input  logic [7:0]        cpu_data,
   output logic              busy,
   output logic              mem_we,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [7:0]        mem_wdata
);

   // Elaboration-time parameter checks
   generate
      if (MEM_AW <= PIX_SHIFT) begin : g_bad_mem
         $error("MEM_AW must exceed the pixel index width");
      end
      if (MEM_AW > BASE_W) begin : g_bad_base
         $error("MEM_AW must not exceed BASE_W");
      end
      if (MODE_W < 3 || NARROW_MODE_W < 1 || NARROW_MODE_W > MODE_W) begin : g_bad_mode
         $error("mode field widths are inconsistent");
      end
      if (NARROW_W < 1 || NARROW_W > PIX_W) begin : g_bad_narrow
         $error("NARROW_W out of range");
      end
      if (EXT_BIT < 0 || EXT_BIT >= PIX_W) begin : g_bad_ext
         $error("EXT_BIT out of range");
      end
   endgenerate

   logic             wide_q;
   logic [PIX_W-1:0] bg_q;
   logic [PIX_W-1:0] fg_q;
   logic [PIX_W-1:0] fg_cap;
   logic [PIX_W-1:0] bg_cap;
   xfer_kind_e       kind;

   cexp_regs #(
      .EXT_BIT  (EXT_BIT),
      .NARROW_W (NARROW_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .wide_q    (wide_q),
      .bg_q      (bg_q),
      .fg_q      (fg_q)
   );

   cexp_mode_decode #(
      .MODE_W        (MODE_W),
      .NARROW_MODE_W (NARROW_MODE_W)
   ) u_decode (
      .wmode (wmode),
      .wide  (wide_q),
      .kind  (kind)
   );

   cexp_expander #(
      .MEM_AW (MEM_AW),
      .BASE_W (BASE_W)
   ) u_expand (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (cpu_we),
      .kind      (kind),
      .base      (cpu_base),
      .off       (cpu_off),
      .data      (cpu_data),
      .fg        (fg_q),
      .bg        (bg_q),
      .busy      (busy),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .fg_cap    (fg_cap),
      .bg_cap    (bg_cap)
   );

endmodule

// File: rtl/cexp_write_engine_chk.sv
module cexp_write_engine_chk #(
   parameter int MEM_AW   = 16,
   parameter int NARROW_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [1:0]        reg_sel,
   input logic [7:0]        reg_wdata,
   input logic              cpu_we,
   input logic              busy,
   input logic              mem_we,
   input logic [MEM_AW-1:0] mem_addr,
   input logic [7:0]        mem_wdata,
   input logic              wide_q,
   input logic [7:0]        fg_q,
   input logic [7:0]        bg_q,
   input logic [7:0]        fg_cap,
   input logic [7:0]        bg_cap
);

   logic [3:0] busy_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    busy_run <= '0;
      else if (busy) busy_run <= busy_run + 1'b1;
      else           busy_run <= '0;
   end

   AST_WIDE_COLOR: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we && reg_sel == 2'd0 && wide_q |=> bg_q == $past(reg_wdata)); // R1

   AST_NARROW_COLOR: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we && reg_sel == 2'd1 && !wide_q |=> (fg_q >> NARROW_W) == 8'h00); // R2

   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> mem_addr == MEM_AW'($past(mem_addr) + 1'b1)); // R4

   AST_COLOR_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      busy && mem_we |-> (mem_wdata == fg_cap || mem_wdata == bg_cap)); // R7

   AST_BUSY_MAX: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> busy_run < 4'd8); // R8

   AST_BUSY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && busy_run != 4'd0 |-> busy_run == 4'd8); // R8

   AST_COLOR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(fg_cap) && $stable(bg_cap)); // R9

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy && !$past(cpu_we) |-> !mem_we); // R11

endmodule

bind cexp_write_engine cexp_write_engine_chk #(
   .MEM_AW   (MEM_AW),
   .NARROW_W (NARROW_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .reg_we    (reg_we),
   .reg_sel   (reg_sel),
   .reg_wdata (reg_wdata),
   .cpu_we    (cpu_we),
   .busy      (busy),
   .mem_we    (mem_we),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .wide_q    (wide_q),
   .fg_q      (fg_q),
   .bg_q      (bg_q),
   .fg_cap    (fg_cap),
   .bg_cap    (bg_cap)
);

// File: tb/cexp_write_engine_test.sv
module cexp_write_engine_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_sel = '0;
   logic [7:0]  reg_wdata = '0;
   logic [2:0]  wmode = '0;
   logic        cpu_we = 1'b0;
   logic [15:0] cpu_base = '0;
   logic [15:0] cpu_off = '0;
   logic [7:0]  cpu_data = '0;
   logic        busy;
   logic        mem_we;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;   // 50 MHz

   cexp_write_engine uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_sel   (reg_sel),
      .reg_wdata (reg_wdata),
      .wmode     (wmode),
      .cpu_we    (cpu_we),
      .cpu_base  (cpu_base),
      .cpu_off   (cpu_off),
      .cpu_data  (cpu_data),
      .busy      (busy),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata)
   );

   typedef struct packed {
      logic [7:0]  ext_c;   // flag while colors are written
      logic [7:0]  fg;
      logic [7:0]  bg;
      logic [7:0]  ext_w;   // flag at the CPU write
      logic [2:0]  wm;
      logic [15:0] base;
      logic [15:0] off;
      logic [7:0]  data;
   } vec_t;

   localparam int NV = 10;
   localparam vec_t VECS [NV] = '{
      '{8'h04, 8'hA5, 8'h3C, 8'h04, 3'd5, 16'h0100, 16'h0010, 8'h96}, // R7 R1 opaque
      '{8'h04, 8'hE1, 8'h12, 8'h04, 3'd4, 16'h0200, 16'h0003, 8'h5A}, // R6 transparent
      '{8'h00, 8'hA7, 8'h3C, 8'h04, 3'd5, 16'h0000, 16'h0020, 8'hF0}, // R2 narrow colors
      '{8'h04, 8'h77, 8'h88, 8'h00, 3'd5, 16'h0040, 16'h0001, 8'hC3}, // R3 mode 5 masked to 1
      '{8'h04, 8'h11, 8'h22, 8'h04, 3'd2, 16'hFFFF, 16'h0002, 8'h3E}, // R10 R11 wrap pass
      '{8'h04, 8'h5D, 8'h00, 8'h04, 3'd4, 16'h2000, 16'h0001, 8'hFF}, // R10 pixel wrap
      '{8'h04, 8'h9C, 8'h44, 8'h04, 3'd4, 16'h0300, 16'h0000, 8'h00}, // R6 nothing written
      '{8'h04, 8'hC8, 8'h31, 8'h0C, 3'd5, 16'h1FFF, 16'h0000, 8'h01}, // R5 last bit only
      '{8'h04, 8'h12, 8'h34, 8'h04, 3'd7, 16'h0500, 16'h0006, 8'hA9}, // R3 mode 7 passes
      '{8'h04, 8'h56, 8'h78, 8'h00, 3'd4, 16'h0600, 16'h0007, 8'h81}  // R3 mode 4 masked to 0
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [1:0] sel, input logic [7:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_sel = sel; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   // kind: 0 pass, 1 transparent, 2 opaque
   // inject: 0 none, 1 foreground rewrite mid-run, 2 CPU write while busy
   task automatic run_xfer(input logic [15:0] base, input logic [15:0] off,
                           input logic [7:0] data, input logic [2:0] wm,
                           input int kind, input logic [7:0] fg, input logic [7:0] bg,
                           input int inject, input string tag);
      logic [15:0] a;
      logic [15:0] p0;
      a  = base + off;
      p0 = a << 3;
      @(negedge clk);
      wmode = wm; cpu_base = base; cpu_off = off; cpu_data = data; cpu_we = 1'b1;
      @(negedge clk);
      cpu_we = 1'b0;
      if (kind == 0) begin
         check({tag, " pass"}, {6'd0, busy, mem_we, mem_addr, mem_wdata},
               {6'd0, 1'b0, 1'b1, a, data});
         @(negedge clk);
         check({tag, " pass single"}, {30'd0, busy, mem_we}, 32'd0);
      end else begin
         for (int i = 0; i < 8; i++) begin
            logic b;
            b = data[7-i];   // R5: bit 7 first
            if (b || kind == 2)
               check({tag, " pixel"}, {6'd0, busy, mem_we, mem_addr, mem_wdata},
                     {6'd0, 1'b1, 1'b1, p0 + 16'(i), b ? fg : bg});
            else
               check({tag, " R6 skip"}, {30'd0, busy, mem_we}, {30'd0, 1'b1, 1'b0});
            if (inject == 1 && i == 2) begin
               reg_we = 1'b1; reg_sel = 2'd1; reg_wdata = 8'h66;
            end
            if (inject == 1 && i == 3) reg_we = 1'b0;
            if (inject == 2 && i == 3) begin
               cpu_we = 1'b1; cpu_data = ~data; cpu_off = off + 16'd5;
            end
            if (inject == 2 && i == 4) cpu_we = 1'b0;
            @(negedge clk);
         end
         check({tag, " R8 end"}, {30'd0, busy, mem_we}, 32'd0);
         @(negedge clk);
         check({tag, " R8 after"}, {30'd0, busy, mem_we}, 32'd0);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R12 reset", {30'd0, busy, mem_we}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12 idle", {30'd0, busy, mem_we}, 32'd0);
      // R12: colors reset to zero, flag clear (mode 5 stays pass-through)
      run_xfer(16'h0010, 16'h0000, 8'h80, 3'd5, 0, 8'h00, 8'h00, 0, "R12 R3");
      reg_wr(2'd2, 8'h04);
      run_xfer(16'h0010, 16'h0000, 8'h80, 3'd5, 2, 8'h00, 8'h00, 0, "R12");

      for (int v = 0; v < NV; v++) begin
         vec_t t;
         logic [7:0] fx, bx;
         logic [2:0] eff;
         int k;
         string tg;
         t = VECS[v];
         reg_wr(2'd2, t.ext_c);
         reg_wr(2'd1, t.fg);
         reg_wr(2'd0, t.bg);
         reg_wr(2'd2, t.ext_w);
         fx  = t.ext_c[2] ? t.fg : {4'h0, t.fg[3:0]};   // R1 R2
         bx  = t.ext_c[2] ? t.bg : {4'h0, t.bg[3:0]};
         eff = t.ext_w[2] ? t.wm : {1'b0, t.wm[1:0]};   // R3
         k   = (eff == 3'd4) ? 1 : (eff == 3'd5) ? 2 : 0;
         tg  = $sformatf("vec %0d R1 R2 R3 R4 R5 R7 R10 R11", v);
         run_xfer(t.base, t.off, t.data, t.wm, k, fx, bx, 0, tg);
      end

      // R9: foreground rewritten during a run does not affect it
      reg_wr(2'd2, 8'h04);
      reg_wr(2'd1, 8'h55);
      reg_wr(2'd0, 8'hAA);
      run_xfer(16'h0700, 16'h0001, 8'hF0, 3'd5, 2, 8'h55, 8'hAA, 1, "R9 during");
      run_xfer(16'h0700, 16'h0002, 8'hF0, 3'd5, 2, 8'h66, 8'hAA, 0, "R9 next");

      // R8: CPU write while busy is dropped
      run_xfer(16'h0800, 16'h0000, 8'hA5, 3'd4, 1, 8'h66, 8'hAA, 2, "R8 stall");

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule